// File: doc/BRIEF.md
# Translation Lookaside Buffer with Hidden Entry Enables

This block is a small fully associative translation buffer. Each entry holds a virtual page number, an address-space identifier, a global flag and a physical frame number. Every entry also has a hidden enable bit that software can neither read nor write. Either reset kind forces the bit to its disabled state. The tag and data arrays are not reset, so whatever they held at power-up, or from before a soft reset, stays in place.

A disabled entry takes no part in lookups. When software writes an entry through the indexed write port, that entry becomes enabled. Because of this, stale or random contents cannot produce a false hit. They also cannot raise a multiple-match shutdown before software has set up the buffer.

The lookup port is combinational. It takes a page number, an address-space identifier and a valid strobe, and in the same cycle it returns a hit, an index, a frame number and a multiple-match flag. A sticky shutdown flag records any multiple match until the next reset. The indexed read port returns only the software-visible fields of an entry.

Top module: `tlb_hidden_init`

## Requirements
- R1: After a cold reset (rst_ni low) or a soft reset (soft_rst_i high at a clock edge), every entry is disabled, and no lookup hits until an entry has been written.
- R2: A write with wr_en_i high enables only the addressed entry, from the next clock edge on. A write presented in the same cycle as soft_rst_i is ignored: neither the fields nor the enable of the entry change.
- R3: A disabled entry never produces a hit and is never counted toward a multiple match, even when its stored tag equals the lookup tag.
- R4: When lk_valid_i is high and two or more enabled entries match, lk_multi_o is 1, lk_hit_o is 1, and lk_idx_o gives the lowest matching index.
- R5: The read port returns, combinationally, the stored page number, identifier, global flag and frame number of entry rd_idx_i. Neither reset kind clears these stored values, and the read port does not expose the hidden bit.
- R6: An entry matches when its page number equals lk_vpn_i and either its identifier equals lk_asid_i or its global flag is 1.
- R7: A single hit gives lk_hit_o = 1 and the entry's index and frame number in the same cycle. On a miss, or when lk_valid_i is 0, lk_hit_o, lk_multi_o, lk_idx_o and lk_pfn_o are all 0.
- R8: shutdown_o becomes 1 at the clock edge that follows a cycle with lk_multi_o = 1. It then stays 1 until a cold or soft reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Cold reset, active low, asynchronous |
| soft_rst_i | input | 1 | Soft reset, active high, synchronous |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | IDX_W | Entry to write |
| wr_vpn_i | input | VPN_W | Page number to store |
| wr_asid_i | input | ASID_W | Identifier to store |
| wr_global_i | input | 1 | Global flag to store |
| wr_pfn_i | input | PFN_W | Frame number to store |
| rd_idx_i | input | IDX_W | Entry to read |
| rd_vpn_o | output | VPN_W | Stored page number |
| rd_asid_o | output | ASID_W | Stored identifier |
| rd_global_o | output | 1 | Stored global flag |
| rd_pfn_o | output | PFN_W | Stored frame number |
| lk_valid_i | input | 1 | Lookup strobe |
| lk_vpn_i | input | VPN_W | Lookup page number |
| lk_asid_i | input | ASID_W | Lookup identifier |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_W | Lowest matching index |
| lk_pfn_o | output | PFN_W | Frame number of that entry |
| lk_multi_o | output | 1 | Two or more enabled entries match |
| shutdown_o | output | 1 | Sticky multiple-match flag |

## Verification
A hidden bit that stays set after a write shows up as a miss on the very next lookup of that entry. A hidden bit that is not forced by reset shows up as a hit on stale contents, or as a multiple match, in the first lookup cycle after the reset. A wrong count or a wrong priority order shows up at once as a wrong lk_multi_o or lk_idx_o in the same cycle as the lookup. Faults in the sticky flag show up one edge later on shutdown_o, and remain visible until the next reset.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_ENTRIES = 8;
  localparam int unsigned TLB_VPN_W   = 20;
  localparam int unsigned TLB_ASID_W  = 8;
  localparam int unsigned TLB_PFN_W   = 20;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int unsigned VPN_W  = tlb_pkg::TLB_VPN_W,
  parameter int unsigned ASID_W = tlb_pkg::TLB_ASID_W,
  parameter int unsigned PFN_W  = tlb_pkg::TLB_PFN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic [VPN_W-1:0]  wvpn_i,
  input  logic [ASID_W-1:0] wasid_i,
  input  logic              wglobal_i,
  input  logic [PFN_W-1:0]  wpfn_i,
  input  logic [VPN_W-1:0]  lvpn_i,
  input  logic [ASID_W-1:0] lasid_i,
  output logic              match_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [ASID_W-1:0] asid_o,
  output logic              global_o,
  output logic [PFN_W-1:0]  pfn_o
);
  logic              hid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic              global_q;
  logic [PFN_W-1:0]  pfn_q;
  logic              wr_ok;

  assign wr_ok = we_i & ~soft_rst_i;

  // Storage is intentionally not reset
  always_ff @(posedge clk_i) begin
    if (wr_ok) begin
      vpn_q    <= wvpn_i;
      asid_q   <= wasid_i;
      global_q <= wglobal_i;
      pfn_q    <= wpfn_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hid_q <= 1'b1;
    else if (soft_rst_i) hid_q <= 1'b1;
    else if (wr_ok)      hid_q <= 1'b0;
  end

  assign match_o  = ~hid_q & (vpn_q == lvpn_i) & (global_q | (asid_q == lasid_i));
  assign vpn_o    = vpn_q;
  assign asid_o   = asid_q;
  assign global_o = global_q;
  assign pfn_o    = pfn_q;
endmodule

// File: rtl/tlb_match_encode.sv
module tlb_match_encode #(
  parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES-1:0] match_i,
  input  logic               valid_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               multi_o
);
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] low_idx;

  always_comb begin
    cnt     = '0;
    low_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_i[i]) begin
        cnt     = cnt + CNT_W'(1);
        low_idx = IDX_W'(i);
      end
    end
  end

  assign hit_o   = valid_i & (cnt != '0);
  assign multi_o = valid_i & (cnt > CNT_W'(1));
  assign idx_o   = hit_o ? low_idx : '0;
endmodule

// File: rtl/tlb_shutdown_flag.sv
module tlb_shutdown_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic multi_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (soft_rst_i) flag_q <= 1'b0;
    else if (multi_i)    flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/tlb_hidden_init.sv
module tlb_hidden_init #(
  parameter int unsigned ENTRIES = tlb_pkg::TLB_ENTRIES,
  parameter int unsigned VPN_W   = tlb_pkg::TLB_VPN_W,
  parameter int unsigned ASID_W  = tlb_pkg::TLB_ASID_W,
  parameter int unsigned PFN_W   = tlb_pkg::TLB_PFN_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [VPN_W-1:0]  wr_vpn_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic              wr_global_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [VPN_W-1:0]  rd_vpn_o,
  output logic [ASID_W-1:0] rd_asid_o,
  output logic              rd_global_o,
  output logic [PFN_W-1:0]  rd_pfn_o,
  input  logic              lk_valid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  output logic              lk_hit_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [PFN_W-1:0]  lk_pfn_o,
  output logic              lk_multi_o,
  output logic              shutdown_o
);
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] ent_we;
  logic [VPN_W-1:0]   ent_vpn    [ENTRIES];
  logic [ASID_W-1:0]  ent_asid   [ENTRIES];
  logic               ent_global [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn    [ENTRIES];
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               multi;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign ent_we[g] = wr_en_i & (wr_idx_i == IDX_W'(g));
    tlb_entry #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_ent (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .soft_rst_i(soft_rst_i),
      .we_i      (ent_we[g]),
      .wvpn_i    (wr_vpn_i),
      .wasid_i   (wr_asid_i),
      .wglobal_i (wr_global_i),
      .wpfn_i    (wr_pfn_i),
      .lvpn_i    (lk_vpn_i),
      .lasid_i   (lk_asid_i),
      .match_o   (match[g]),
      .vpn_o     (ent_vpn[g]),
      .asid_o    (ent_asid[g]),
      .global_o  (ent_global[g]),
      .pfn_o     (ent_pfn[g])
    );
  end

  tlb_match_encode #(.ENTRIES(ENTRIES)) u_enc (
    .match_i(match),
    .valid_i(lk_valid_i),
    .hit_o  (hit),
    .idx_o  (hit_idx),
    .multi_o(multi)
  );

  tlb_shutdown_flag u_sd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .multi_i   (multi),
    .flag_o    (shutdown_o)
  );

  assign lk_hit_o    = hit;
  assign lk_idx_o    = hit_idx;
  assign lk_multi_o  = multi;
  assign lk_pfn_o    = hit ? ent_pfn[hit_idx] : '0;

  assign rd_vpn_o    = ent_vpn[rd_idx_i];
  assign rd_asid_o   = ent_asid[rd_idx_i];
  assign rd_global_o = ent_global[rd_idx_i];
  assign rd_pfn_o    = ent_pfn[rd_idx_i];
endmodule

// File: rtl/tlb_hidden_init_chk.sv
module tlb_hidden_init_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic soft_rst_i,
  input logic lk_valid_i,
  input logic lk_hit_o,
  input logic lk_multi_o,
  input logic shutdown_o
);
  AST_MULTI_HAS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_multi_o |-> lk_hit_o); // R4
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |-> (!lk_hit_o && !lk_multi_o)); // R7
  AST_SOFT_DISABLES_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !lk_hit_o); // R1
  AST_SHUTDOWN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_multi_o && !soft_rst_i) |=> shutdown_o); // R8
  AST_SHUTDOWN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shutdown_o && !soft_rst_i) |=> shutdown_o); // R8
  AST_SHUTDOWN_SOFT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !shutdown_o); // R8
endmodule

bind tlb_hidden_init tlb_hidden_init_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .soft_rst_i(soft_rst_i),
  .lk_valid_i(lk_valid_i),
  .lk_hit_o  (lk_hit_o),
  .lk_multi_o(lk_multi_o),
  .shutdown_o(shutdown_o)
);

// File: tb/tb_tlb_hidden_init.sv
module tb_tlb_hidden_init;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_idx_i = '0;
  logic [19:0] wr_vpn_i = '0;
  logic [7:0]  wr_asid_i = '0;
  logic        wr_global_i = 1'b0;
  logic [19:0] wr_pfn_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [19:0] rd_vpn_o;
  logic [7:0]  rd_asid_o;
  logic        rd_global_o;
  logic [19:0] rd_pfn_o;
  logic        lk_valid_i = 1'b0;
  logic [19:0] lk_vpn_i = '0;
  logic [7:0]  lk_asid_i = '0;
  logic        lk_hit_o;
  logic [2:0]  lk_idx_o;
  logic [19:0] lk_pfn_o;
  logic        lk_multi_o;
  logic        shutdown_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_hidden_init dut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_vpn_i(wr_vpn_i),
    .wr_asid_i(wr_asid_i), .wr_global_i(wr_global_i), .wr_pfn_i(wr_pfn_i),
    .rd_idx_i(rd_idx_i), .rd_vpn_o(rd_vpn_o), .rd_asid_o(rd_asid_o),
    .rd_global_o(rd_global_o), .rd_pfn_o(rd_pfn_o),
    .lk_valid_i(lk_valid_i), .lk_vpn_i(lk_vpn_i), .lk_asid_i(lk_asid_i),
    .lk_hit_o(lk_hit_o), .lk_idx_o(lk_idx_o), .lk_pfn_o(lk_pfn_o),
    .lk_multi_o(lk_multi_o), .shutdown_o(shutdown_o)
  );

  typedef struct packed {
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic        hit;
    logic [2:0]  idx;
    logic [19:0] pfn;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{vpn: 20'h00100, asid: 8'h00, hit: 1'b1, idx: 3'd0, pfn: 20'hA0000},
    '{vpn: 20'h00103, asid: 8'h03, hit: 1'b1, idx: 3'd3, pfn: 20'hA0003},
    '{vpn: 20'h00103, asid: 8'h04, hit: 1'b0, idx: 3'd0, pfn: 20'h00000},
    '{vpn: 20'h00105, asid: 8'h55, hit: 1'b1, idx: 3'd5, pfn: 20'hA0005},
    '{vpn: 20'h00777, asid: 8'h01, hit: 1'b0, idx: 3'd0, pfn: 20'h00000},
    '{vpn: 20'h00104, asid: 8'h04, hit: 1'b1, idx: 3'd4, pfn: 20'hA0004},
    '{vpn: 20'h001FF, asid: 8'h00, hit: 1'b0, idx: 3'd0, pfn: 20'h00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [19:0] vpn, input logic [7:0] asid,
                    input logic g, input logic [19:0] pfn);
    @(negedge clk);
    wr_en_i = 1'b1; wr_idx_i = idx; wr_vpn_i = vpn; wr_asid_i = asid;
    wr_global_i = g; wr_pfn_i = pfn;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic look(input logic [19:0] vpn, input logic [7:0] asid);
    lk_valid_i = 1'b1; lk_vpn_i = vpn; lk_asid_i = asid;
    #1;
  endtask

  task automatic soft_pulse();
    @(negedge clk);
    soft_rst_i = 1'b1;
    @(negedge clk);
    soft_rst_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R8 reset shutdown", 32'(shutdown_o), 0);
    look(20'h0, 8'h0);
    chk("R1 reset no hit", 32'(lk_hit_o), 0);

    // duplicate tags in every entry
    for (int i = 0; i < 8; i++) wr(3'(i), 20'h00777, 8'h01, 1'b0, 20'hB0000 + 20'(i));
    look(20'h00777, 8'h01);
    chk("R4 multi flag", 32'(lk_multi_o), 1);
    chk("R4 multi hit", 32'(lk_hit_o), 1);
    chk("R4 lowest index", 32'(lk_idx_o), 0);
    @(negedge clk);
    chk("R8 shutdown set", 32'(shutdown_o), 1);
    look(20'h00999, 8'h01);
    @(negedge clk);
    chk("R8 shutdown held", 32'(shutdown_o), 1);
    lk_valid_i = 1'b0;
    look(20'h00777, 8'h01); lk_valid_i = 1'b0; #1;
    chk("R7 valid low no hit", 32'(lk_hit_o), 0);
    chk("R7 valid low no multi", 32'(lk_multi_o), 0);

    soft_pulse();
    chk("R8 soft clears shutdown", 32'(shutdown_o), 0);
    look(20'h00777, 8'h01);
    chk("R1 soft disables hit", 32'(lk_hit_o), 0);
    chk("R3 disabled not counted", 32'(lk_multi_o), 0);
    rd_idx_i = 3'd2; #1;
    chk("R5 vpn kept", 32'(rd_vpn_o), 32'h777);
    chk("R5 pfn kept", 32'(rd_pfn_o), 32'hB0002);
    chk("R5 asid kept", 32'(rd_asid_o), 32'h01);
    lk_valid_i = 1'b0;

    for (int i = 0; i < 6; i++)
      wr(3'(i), 20'h00100 + 20'(i), 8'(i), (i == 5), 20'hA0000 + 20'(i));
    rd_idx_i = 3'd5; #1;
    chk("R5 global read", 32'(rd_global_o), 1);

    for (int v = 0; v < NVEC; v++) begin
      look(VEC[v].vpn, VEC[v].asid);
      chk($sformatf("R6 R7 vec%0d hit", v), 32'(lk_hit_o), 32'(VEC[v].hit));
      chk($sformatf("R7 vec%0d idx", v), 32'(lk_idx_o), 32'(VEC[v].idx));
      chk($sformatf("R7 vec%0d pfn", v), 32'(lk_pfn_o), 32'(VEC[v].pfn));
      chk($sformatf("R3 vec%0d multi", v), 32'(lk_multi_o), 0);
      @(negedge clk);
    end
    lk_valid_i = 1'b0;

    // R2: enable entry 6 only; entry 7 still disabled with same tag
    wr(3'd6, 20'h00777, 8'h01, 1'b0, 20'hC0006);
    look(20'h00777, 8'h01);
    chk("R2 single enable hit", 32'(lk_hit_o), 1);
    chk("R2 single enable idx", 32'(lk_idx_o), 6);
    chk("R2 single enable pfn", 32'(lk_pfn_o), 32'hC0006);
    chk("R3 entry7 not counted", 32'(lk_multi_o), 0);
    lk_valid_i = 1'b0;
    @(negedge clk);
    chk("R8 no shutdown on single", 32'(shutdown_o), 0);

    // R2: write during soft reset ignored
    @(negedge clk);
    soft_rst_i = 1'b1; wr_en_i = 1'b1; wr_idx_i = 3'd1;
    wr_vpn_i = 20'h00ABC; wr_asid_i = 8'h09; wr_global_i = 1'b1; wr_pfn_i = 20'hDDDDD;
    @(negedge clk);
    soft_rst_i = 1'b0; wr_en_i = 1'b0;
    rd_idx_i = 3'd1; #1;
    chk("R2 soft write vpn ignored", 32'(rd_vpn_o), 32'h101);
    look(20'h00ABC, 8'h09);
    chk("R2 soft write no enable", 32'(lk_hit_o), 0);
    look(20'h00101, 8'h01);
    chk("R1 soft entry1 disabled", 32'(lk_hit_o), 0);
    lk_valid_i = 1'b0;

    // R4/R8: two enabled duplicates, then cold reset
    wr(3'd2, 20'h00555, 8'h07, 1'b1, 20'hE0002);
    wr(3'd4, 20'h00555, 8'h07, 1'b0, 20'hE0004);
    look(20'h00555, 8'h07);
    chk("R4 two enabled multi", 32'(lk_multi_o), 1);
    chk("R4 two enabled idx", 32'(lk_idx_o), 2);
    chk("R4 two enabled pfn", 32'(lk_pfn_o), 32'hE0002);
    look(20'h00555, 8'h33);
    chk("R6 global only match", 32'(lk_idx_o), 2);
    chk("R6 global only single", 32'(lk_multi_o), 0);
    look(20'h00555, 8'h07);
    @(negedge clk);
    chk("R8 shutdown again", 32'(shutdown_o), 1);
    lk_valid_i = 1'b0;
    rst_ni = 1'b0;
    #1;
    chk("R8 cold clears shutdown", 32'(shutdown_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    look(20'h00555, 8'h07);
    chk("R1 cold disables hit", 32'(lk_hit_o), 0);
    chk("R3 cold no multi", 32'(lk_multi_o), 0);
    rd_idx_i = 3'd4; #1;
    chk("R5 cold keeps pfn", 32'(rd_pfn_o), 32'hE0004);
    lk_valid_i = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule